// File: doc/BRIEF.md
# Eight-Channel Timer Unit with Grouped Interrupts

The block holds eight identical 16-bit timer channels and one 64-bit system timer, all programmed over a simple word-addressed register bus. Each channel picks its count tick from the core clock, a real-time tick or an external tick. The tick then passes through a per-channel prescaler. The counter counts up to a full value, wraps to zero and raises a full flag. When it reaches a half value it raises a half flag. The same two values shape a PWM waveform on the channel's output pin. With interrupts masked and the pin disabled, the channel is a plain event counter or a periodic timer.

The system timer uses the same control-byte layout as the channels. Its 64-bit count is read as two 32-bit words: reading the low word captures the high word, so a carry between the two reads cannot tear the value. A shared gate register stops the channels and the system timer, and also drives the watchdog clock enable. Sticky flags pass through a mask onto three interrupt lines. Channel 5 has a line of its own, the other seven channels share a second line, and the system timer has a third.

Register map, as word addresses. The plain address of each 3-word group writes the whole register, the next address sets the bits written as 1, and the one after that clears them:
- 0x00/0x01/0x02 enable (bits 7:0 channels, bit 8 system timer)
- 0x04/0x05/0x06 gate (bits 7:0 channels, bit 8 watchdog, bit 9 system timer)
- 0x0C/0x0D/0x0E mask
- 0x08 flag read, 0x0A flag clear
- 0x10 system control byte, 0x11/0x12 compare low/high, 0x13 count low, 0x14 latched count high
- Channel n: 0x20+4n control byte, +1 half value, +2 full value, +3 count

Top module: `tmr_unit`

## Requirements
- R1: After synchronous reset, enable, gate, flag registers and all counters are zero, every mask bit is 1, and all outputs are low except wdt_clk_en, which is high.
- R2: Control byte bits [2:0] select the tick source: bit 0 the core clock (every cycle), bit 1 rtc_tick, bit 2 ext_tick; selected sources are ORed, and a zero field stops counting.
- R3: Control byte bits [5:3] select the prescale divider: codes 0 to 5 give 1, 4, 16, 64, 256 and 1024 source ticks per count, and codes 6 and 7 give 1024.
- R4: On a count tick at which count+1 is at least the full value, the counter becomes 0 and flag bit n (channel n full) is set; otherwise the counter increments.
- R5: On a count tick at which count+1 equals the half value, flag bit 8+n (channel n half) is set.
- R6: pwm_out[n] is high exactly when control byte bit 7 is 1 and the channel count is below its half value.
- R7: A channel whose enable bit is 0 holds its count and prescaler at 0; a gated enabled channel freezes its count; gate bit 8 low drives wdt_clk_en high.
- R8: Flags are sticky until a 1 is written to the same bit at the clear address 0x0A; a flag event in the same cycle as its clear leaves the flag set.
- R9: Writes to set and clear aliases of enable, gate and mask change only the bits written as 1.
- R10: irq_solo is the OR of unmasked flags 5 and 13, irq_sys is unmasked flag 16, and irq_shared is the OR of the other unmasked channel flags; a mask bit of 1 blocks its flag.
- R11: The system timer counts ticks from its own control byte, enable bit 8 and gate bit 9, holds its value while disabled or gated, and sets flag 16 on the tick at which count+1 equals the 64-bit compare value.
- R12: A read of 0x13 returns count bits [31:0] and captures bits [63:32]; a read of 0x14 returns the captured word.
- R13: A write to a channel's count address loads that value into the counter and suppresses that cycle's count tick and its flags.
- R14: Reads return data one cycle after bus_rd, from the register state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the fastest tick source |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| rtc_tick | input | 1 | Real-time tick enable pulse |
| ext_tick | input | 1 | External tick enable pulse |
| pwm_out | output | 8 | Per-channel PWM waveforms |
| irq_solo | output | 1 | Interrupt line for channel 5 |
| irq_shared | output | 1 | Interrupt line for channels 0-4 and 6-7 |
| irq_sys | output | 1 | Interrupt line for the system timer |
| wdt_clk_en | output | 1 | Watchdog clock enable from the gate register |

## Verification
The assertions check on every cycle that a wrap leaves the counter at zero, that a disabled channel sits at zero, and that a gated channel freezes. They also check that a loaded count lands, that a prescaler restarts after each tick, that flags stay set without a clear, and that the high word is captured on a low read. The divider ratios, the tick-source choice, the exact cycles of the half and full flags, and the PWM duty can only be shown by the bench's scenarios, which follow the block against a behavioural model. The same holds for the set-wins-over-clear race, the interrupt grouping under changing masks, and the read latency.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCH      = 8;
    localparam int ENW      = NCH + 1;
    localparam int GATEW    = NCH + 2;
    localparam int FLAGW    = 2 * NCH + 1;
    localparam int SYS_FLAG = 2 * NCH;
    localparam int WDT_GATE = NCH;
    localparam int SYS_GATE = NCH + 1;
    localparam int SYS_EN   = NCH;
    localparam int SOLO_CH  = 5;
    localparam int PSW      = 10;
    localparam int AW       = 6;
    localparam int DW       = 32;

    localparam logic [AW-1:0] A_EN       = 6'h00;
    localparam logic [AW-1:0] A_EN_SET   = 6'h01;
    localparam logic [AW-1:0] A_EN_CLR   = 6'h02;
    localparam logic [AW-1:0] A_GATE     = 6'h04;
    localparam logic [AW-1:0] A_GATE_SET = 6'h05;
    localparam logic [AW-1:0] A_GATE_CLR = 6'h06;
    localparam logic [AW-1:0] A_FLAG     = 6'h08;
    localparam logic [AW-1:0] A_FLAG_CLR = 6'h0A;
    localparam logic [AW-1:0] A_MASK     = 6'h0C;
    localparam logic [AW-1:0] A_MASK_SET = 6'h0D;
    localparam logic [AW-1:0] A_MASK_CLR = 6'h0E;
    localparam logic [AW-1:0] A_SCSR     = 6'h10;
    localparam logic [AW-1:0] A_SCMP_LO  = 6'h11;
    localparam logic [AW-1:0] A_SCMP_HI  = 6'h12;
    localparam logic [AW-1:0] A_SCNT_LO  = 6'h13;
    localparam logic [AW-1:0] A_SCNT_HI  = 6'h14;

    // control byte: bit 7 pwm enable, bits 5:3 prescale, bits 2:0 source
    typedef struct packed {
        logic       pwm_en;
        logic       spare;
        logic [2:0] presc;
        logic [2:0] src;
    } csr_t;

    typedef enum logic [1:0] {
        CR_CSR  = 2'd0,
        CR_HALF = 2'd1,
        CR_FULL = 2'd2,
        CR_CNT  = 2'd3
    } ch_reg_e;

    // last prescaler count before a tick is emitted
    function automatic logic [PSW-1:0] presc_last(input logic [2:0] code);
        case (code)
            3'd0:    presc_last = 10'd0;
            3'd1:    presc_last = 10'd3;
            3'd2:    presc_last = 10'd15;
            3'd3:    presc_last = 10'd63;
            3'd4:    presc_last = 10'd255;
            default: presc_last = 10'd1023;
        endcase
    endfunction

    function automatic logic src_hit(input logic [2:0] sel, input logic rtc, input logic ext);
        src_hit = sel[0] | (sel[1] & rtc) | (sel[2] & ext);
    endfunction

    function automatic logic [2*NCH-1:0] solo_sel();
        logic [2*NCH-1:0] v;
        v = '0;
        v[SOLO_CH]       = 1'b1;
        v[NCH + SOLO_CH] = 1'b1;
        solo_sel = v;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic run,
    input  csr_t cfg,
    input  logic rtc_tick,
    input  logic ext_tick,
    output logic tick
);

    logic [PSW-1:0] pcnt;
    logic           src;

    always_comb begin
        src  = src_hit(cfg.src, rtc_tick, ext_tick);
        tick = enable && run && src && (pcnt >= presc_last(cfg.presc));
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pcnt <= '0;
        end else if (run && src) begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
        end
    end

    // R3: every emitted tick restarts the division
    p_restart_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pcnt == '0));

    // R7: a disabled prescaler stays cleared
    p_idle_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (pcnt == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          run,
    input  csr_t          cfg,
    input  logic [CW-1:0] half_val,
    input  logic [CW-1:0] full_val,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          rtc_tick,
    input  logic          ext_tick,
    output logic [CW-1:0] count,
    output logic          half_hit,
    output logic          full_hit,
    output logic          pwm
);

    logic          tick;
    logic          adv;
    logic [CW:0]   nxt;

    tmr_prescaler u_presc (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .run      (run),
        .cfg      (cfg),
        .rtc_tick (rtc_tick),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    always_comb begin
        nxt      = {1'b0, count} + 1'b1;
        adv      = tick && !cnt_we;
        full_hit = adv && (nxt >= {1'b0, full_val});
        half_hit = adv && (nxt == {1'b0, half_val});
        pwm      = cfg.pwm_en && (count < half_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (cnt_we) begin
            count <= cnt_wdata;
        end else if (!enable) begin
            count <= '0;
        end else if (adv) begin
            count <= full_hit ? '0 : nxt[CW-1:0];
        end
    end

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        full_hit |=> (count == '0));

    p_disabled_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (!enable && !cnt_we) |=> (count == '0));

    p_gate_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (enable && !run && !cnt_we) |=> $stable(count));

    p_load_r13: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (count == $past(cnt_wdata)));

endmodule

// File: rtl/tmr_systimer.sv
module tmr_systimer
    import tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        run,
    input  csr_t        cfg,
    input  logic [63:0] cmp_val,
    input  logic        rtc_tick,
    input  logic        ext_tick,
    input  logic        rd_lo,
    output logic [31:0] cnt_lo,
    output logic [31:0] hi_latched,
    output logic        hit
);

    logic        tick;
    logic [63:0] cnt;
    logic [63:0] nxt;

    tmr_prescaler u_presc (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .run      (run),
        .cfg      (cfg),
        .rtc_tick (rtc_tick),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    always_comb begin
        nxt    = cnt + 64'd1;
        hit    = tick && (nxt == cmp_val);
        cnt_lo = cnt[31:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            hi_latched <= '0;
        end else begin
            if (tick) begin
                cnt <= nxt;
            end
            if (rd_lo) begin
                hi_latched <= cnt[63:32];
            end
        end
    end

    p_latch_r12: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> (hi_latched == $past(cnt[63:32])));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!enable || !run) |=> $stable(cnt));

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          rtc_tick,
    input  logic          ext_tick,
    output logic [NCH-1:0] pwm_out,
    output logic          irq_solo,
    output logic          irq_shared,
    output logic          irq_sys,
    output logic          wdt_clk_en
);

    localparam logic [2*NCH-1:0] SOLO_BITS = solo_sel();

    logic [ENW-1:0]   en_q;
    logic [GATEW-1:0] gate_q;
    logic [FLAGW-1:0] mask_q;
    logic [FLAGW-1:0] flag_q;
    logic [FLAGW-1:0] hits;
    logic [FLAGW-1:0] flag_clr;
    logic [FLAGW-1:0] pend;
    csr_t             csr_q  [NCH];
    logic [CW-1:0]    half_q [NCH];
    logic [CW-1:0]    full_q [NCH];
    logic [CW-1:0]    ch_cnt [NCH];
    logic [NCH-1:0]   ch_half_hit;
    logic [NCH-1:0]   ch_full_hit;
    logic [NCH-1:0]   cnt_we;
    csr_t             scsr_q;
    logic [63:0]      scmp_q;
    logic [31:0]      scnt_lo;
    logic [31:0]      shi_latched;
    logic             sys_hit;
    logic             rd_lo;
    logic             ch_space;
    logic [2:0]       ch_idx;
    ch_reg_e          ch_reg;
    logic [DW-1:0]    rd_mux;

    always_comb begin
        ch_space = bus_addr[AW-1];
        ch_idx   = bus_addr[4:2];
        ch_reg   = ch_reg_e'(bus_addr[1:0]);
        rd_lo    = bus_rd && (bus_addr == A_SCNT_LO);
        flag_clr = (bus_wr && bus_addr == A_FLAG_CLR) ? bus_wdata[FLAGW-1:0] : '0;
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            assign cnt_we[g] = bus_wr && ch_space && (ch_idx == g) && (ch_reg == CR_CNT);

            tmr_channel #(.CW(CW)) u_ch (
                .clk       (clk),
                .rst       (rst),
                .enable    (en_q[g]),
                .run       (!gate_q[g]),
                .cfg       (csr_q[g]),
                .half_val  (half_q[g]),
                .full_val  (full_q[g]),
                .cnt_we    (cnt_we[g]),
                .cnt_wdata (bus_wdata[CW-1:0]),
                .rtc_tick  (rtc_tick),
                .ext_tick  (ext_tick),
                .count     (ch_cnt[g]),
                .half_hit  (ch_half_hit[g]),
                .full_hit  (ch_full_hit[g]),
                .pwm       (pwm_out[g])
            );
        end
    endgenerate

    tmr_systimer u_sys (
        .clk        (clk),
        .rst        (rst),
        .enable     (en_q[SYS_EN]),
        .run        (!gate_q[SYS_GATE]),
        .cfg        (scsr_q),
        .cmp_val    (scmp_q),
        .rtc_tick   (rtc_tick),
        .ext_tick   (ext_tick),
        .rd_lo      (rd_lo),
        .cnt_lo     (scnt_lo),
        .hi_latched (shi_latched),
        .hit        (sys_hit)
    );

    assign hits = {sys_hit, ch_half_hit, ch_full_hit};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            gate_q <= '0;
            mask_q <= '1;
            flag_q <= '0;
            scsr_q <= '0;
            scmp_q <= '0;
            for (int i = 0; i < NCH; i++) begin
                csr_q[i]  <= '0;
                half_q[i] <= '0;
                full_q[i] <= '0;
            end
        end else begin
            flag_q <= (flag_q & ~flag_clr) | hits;
            if (bus_wr) begin
                case (bus_addr)
                    A_EN:       en_q   <= bus_wdata[ENW-1:0];
                    A_EN_SET:   en_q   <= en_q | bus_wdata[ENW-1:0];
                    A_EN_CLR:   en_q   <= en_q & ~bus_wdata[ENW-1:0];
                    A_GATE:     gate_q <= bus_wdata[GATEW-1:0];
                    A_GATE_SET: gate_q <= gate_q | bus_wdata[GATEW-1:0];
                    A_GATE_CLR: gate_q <= gate_q & ~bus_wdata[GATEW-1:0];
                    A_MASK:     mask_q <= bus_wdata[FLAGW-1:0];
                    A_MASK_SET: mask_q <= mask_q | bus_wdata[FLAGW-1:0];
                    A_MASK_CLR: mask_q <= mask_q & ~bus_wdata[FLAGW-1:0];
                    A_SCSR:     scsr_q <= csr_t'(bus_wdata[7:0]);
                    A_SCMP_LO:  scmp_q[31:0]  <= bus_wdata;
                    A_SCMP_HI:  scmp_q[63:32] <= bus_wdata;
                    default: begin
                        if (ch_space) begin
                            case (ch_reg)
                                CR_CSR:  csr_q[ch_idx]  <= csr_t'(bus_wdata[7:0]);
                                CR_HALF: half_q[ch_idx] <= bus_wdata[CW-1:0];
                                CR_FULL: full_q[ch_idx] <= bus_wdata[CW-1:0];
                                default: ;
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_EN, A_EN_SET, A_EN_CLR:       rd_mux[ENW-1:0]   = en_q;
            A_GATE, A_GATE_SET, A_GATE_CLR: rd_mux[GATEW-1:0] = gate_q;
            A_MASK, A_MASK_SET, A_MASK_CLR: rd_mux[FLAGW-1:0] = mask_q;
            A_FLAG:                         rd_mux[FLAGW-1:0] = flag_q;
            A_SCSR:                         rd_mux[7:0]       = scsr_q;
            A_SCMP_LO:                      rd_mux            = scmp_q[31:0];
            A_SCMP_HI:                      rd_mux            = scmp_q[63:32];
            A_SCNT_LO:                      rd_mux            = scnt_lo;
            A_SCNT_HI:                      rd_mux            = shi_latched;
            default: begin
                if (ch_space) begin
                    case (ch_reg)
                        CR_CSR:  rd_mux[7:0]    = csr_q[ch_idx];
                        CR_HALF: rd_mux[CW-1:0] = half_q[ch_idx];
                        CR_FULL: rd_mux[CW-1:0] = full_q[ch_idx];
                        default: rd_mux[CW-1:0] = ch_cnt[ch_idx];
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    always_comb begin
        pend       = flag_q & ~mask_q;
        irq_solo   = |(pend[2*NCH-1:0] & SOLO_BITS);
        irq_shared = |(pend[2*NCH-1:0] & ~SOLO_BITS);
        irq_sys    = pend[SYS_FLAG];
        wdt_clk_en = !gate_q[WDT_GATE];
    end

    // R8: without a clear write, no set flag drops
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == A_FLAG_CLR) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R10: the solo line stays quiet while both of its flags are masked
    p_solo_masked_r10: assert property (@(posedge clk) disable iff (rst)
        (mask_q[SOLO_CH] && mask_q[NCH + SOLO_CH]) |-> !irq_solo);

    // R10: a fresh channel-5 event with an open mask shows on the solo line next cycle
    p_solo_raise_r10: assert property (@(posedge clk) disable iff (rst)
        (ch_full_hit[SOLO_CH] && !mask_q[SOLO_CH] && !(bus_wr && (bus_addr == A_MASK || bus_addr == A_MASK_SET)))
        |=> irq_solo);

endmodule

// File: tb/tb_tmr_unit.sv
`timescale 1ns/1ps
module tb_tmr_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rtc_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic [7:0]  pwm_out;
    logic        irq_solo, irq_shared, irq_sys, wdt_clk_en;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 0;
    string cur_tag = "R14";

    always #4 clk = ~clk;

    tmr_unit dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rtc_tick(rtc_tick), .ext_tick(ext_tick), .pwm_out(pwm_out),
        .irq_solo(irq_solo), .irq_shared(irq_shared), .irq_sys(irq_sys),
        .wdt_clk_en(wdt_clk_en)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_csr  [8];
    logic [15:0] m_half [8];
    logic [15:0] m_full [8];
    logic [15:0] m_cnt  [8];
    int          m_pc   [8];
    logic [8:0]  m_en;
    logic [9:0]  m_gate;
    logic [16:0] m_flag, m_mask;
    logic [7:0]  m_scsr;
    logic [63:0] m_cmp, m_scnt;
    logic [31:0] m_hi, m_rdata;
    int          m_spc;
    bit          m_rvalid;
    string       m_rtag;

    function automatic int div_last(input logic [2:0] c);
        if (c >= 3'd5) return 1023;
        return (4 ** c) - 1;
    endfunction

    function automatic bit src_on(input logic [7:0] c);
        return c[0] || (c[1] && rtc_tick) || (c[2] && ext_tick);
    endfunction

    function automatic logic [31:0] model_read(input logic [5:0] a);
        int ch;
        ch = a[4:2];
        if (a[5]) begin
            case (a[1:0])
                2'd0: return {24'd0, m_csr[ch]};
                2'd1: return {16'd0, m_half[ch]};
                2'd2: return {16'd0, m_full[ch]};
                default: return {16'd0, m_cnt[ch]};
            endcase
        end
        case (a)
            6'h00, 6'h01, 6'h02: return {23'd0, m_en};
            6'h04, 6'h05, 6'h06: return {22'd0, m_gate};
            6'h0C, 6'h0D, 6'h0E: return {15'd0, m_mask};
            6'h08: return {15'd0, m_flag};
            6'h10: return {24'd0, m_scsr};
            6'h11: return m_cmp[31:0];
            6'h12: return m_cmp[63:32];
            6'h13: return m_scnt[31:0];
            6'h14: return m_hi;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [16:0] hits;
        logic [16:0] clr;
        bit tk;
        bit we;
        int n;
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                m_csr[i] = 0; m_half[i] = 0; m_full[i] = 0; m_cnt[i] = 0; m_pc[i] = 0;
            end
            m_en = 0; m_gate = 0; m_flag = 0; m_mask = '1; m_scsr = 0;
            m_cmp = 0; m_scnt = 0; m_hi = 0; m_rdata = 0; m_spc = 0; m_rvalid = 0;
        end else begin
            hits = 0;
            m_rvalid = bus_rd;
            if (bus_rd) begin
                m_rdata = model_read(bus_addr);
                m_rtag  = cur_tag;
                if (bus_addr == 6'h13) m_hi = m_scnt[63:32];
            end
            for (int i = 0; i < 8; i++) begin
                tk = 0;
                we = bus_wr && bus_addr[5] && (bus_addr[4:2] == i[2:0]) && (bus_addr[1:0] == 2'd3);
                if (!m_en[i]) m_pc[i] = 0;
                else if (!m_gate[i] && src_on(m_csr[i])) begin
                    if (m_pc[i] >= div_last(m_csr[i][5:3])) begin m_pc[i] = 0; tk = 1; end
                    else m_pc[i] = m_pc[i] + 1;
                end
                if (we) m_cnt[i] = bus_wdata[15:0];
                else if (!m_en[i]) m_cnt[i] = 0;
                else if (tk) begin
                    n = int'(m_cnt[i]) + 1;
                    if (n == int'(m_half[i])) hits[8+i] = 1;
                    if (n >= int'(m_full[i])) begin hits[i] = 1; m_cnt[i] = 0; end
                    else m_cnt[i] = n[15:0];
                end
            end
            tk = 0;
            if (!m_en[8]) m_spc = 0;
            else if (!m_gate[9] && src_on(m_scsr)) begin
                if (m_spc >= div_last(m_scsr[5:3])) begin m_spc = 0; tk = 1; end
                else m_spc = m_spc + 1;
            end
            if (tk) begin
                if (m_scnt + 64'd1 == m_cmp) hits[16] = 1;
                m_scnt = m_scnt + 64'd1;
            end
            clr = (bus_wr && bus_addr == 6'h0A) ? bus_wdata[16:0] : 17'd0;
            m_flag = (m_flag & ~clr) | hits;
            if (bus_wr) begin
                case (bus_addr)
                    6'h00: m_en = bus_wdata[8:0];
                    6'h01: m_en = m_en | bus_wdata[8:0];
                    6'h02: m_en = m_en & ~bus_wdata[8:0];
                    6'h04: m_gate = bus_wdata[9:0];
                    6'h05: m_gate = m_gate | bus_wdata[9:0];
                    6'h06: m_gate = m_gate & ~bus_wdata[9:0];
                    6'h0C: m_mask = bus_wdata[16:0];
                    6'h0D: m_mask = m_mask | bus_wdata[16:0];
                    6'h0E: m_mask = m_mask & ~bus_wdata[16:0];
                    6'h10: m_scsr = bus_wdata[7:0];
                    6'h11: m_cmp[31:0] = bus_wdata;
                    6'h12: m_cmp[63:32] = bus_wdata;
                    default: if (bus_addr[5]) begin
                        case (bus_addr[1:0])
                            2'd0: m_csr[bus_addr[4:2]]  = bus_wdata[7:0];
                            2'd1: m_half[bus_addr[4:2]] = bus_wdata[15:0];
                            2'd2: m_full[bus_addr[4:2]] = bus_wdata[15:0];
                            default: ;
                        endcase
                    end
                endcase
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(posedge clk) begin : compare
        logic [7:0]  e_pwm;
        logic [16:0] pend;
        bit e_solo, e_shared, e_sys;
        #2;
        for (int i = 0; i < 8; i++) e_pwm[i] = m_csr[i][7] && (m_cnt[i] < m_half[i]);
        pend     = m_flag & ~m_mask;
        e_solo   = pend[5] || pend[13];
        e_shared = |(pend[15:0] & ~16'h2020);
        e_sys    = pend[16];
        ntests++;
        if (pwm_out !== e_pwm) begin
            nfail++; $display("FAIL R6 pwm_out actual %h expected %h", pwm_out, e_pwm);
        end
        ntests++;
        if ({irq_solo, irq_shared, irq_sys} !== {e_solo, e_shared, e_sys}) begin
            nfail++; $display("FAIL R10 irq lines actual %b expected %b",
                {irq_solo, irq_shared, irq_sys}, {e_solo, e_shared, e_sys});
        end
        ntests++;
        if (wdt_clk_en !== !m_gate[8]) begin
            nfail++; $display("FAIL R7 wdt_clk_en actual %b expected %b", wdt_clk_en, !m_gate[8]);
        end
        if (m_rvalid) begin
            ntests++;
            if (bus_rdata !== m_rdata) begin
                nfail++; $display("FAIL %s R14 read actual %h expected %h", m_rtag, bus_rdata, m_rdata);
            end
        end
    end

    // ---------------- stimulus ----------------
    initial begin : tick_gen
        int k;
        k = 0;
        forever begin
            @(negedge clk);
            k++;
            rtc_tick = (k % 3 == 0);
            ext_tick = (k % 5 == 0);
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; cur_tag = tag;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin : main
        idle(3);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        rd(6'h00, "R1"); rd(6'h04, "R1"); rd(6'h0C, "R1"); rd(6'h08, "R1"); rd(6'h23, "R1");

        // ch0: core clock, divide 1, pwm on, half 3, full 6 (R4 R5 R6)
        wr(6'h20, 32'h81); wr(6'h21, 3); wr(6'h22, 6);
        // ch5: rtc, divide 4 (R2 R3)
        wr(6'h34, 32'h0A); wr(6'h35, 2); wr(6'h36, 5);
        // ch1: no source selected (R2)
        wr(6'h24, 32'h80); wr(6'h25, 4); wr(6'h26, 9);
        // ch3: code 7 clamps to 1024 (R3)
        wr(6'h2C, 32'h39); wr(6'h2D, 1); wr(6'h2E, 3);
        // ch2: ext, code 5 (R3)
        wr(6'h28, 32'h2C); wr(6'h29, 1); wr(6'h2A, 2);
        // ch4: ext or rtc, pwm on (R2)
        wr(6'h30, 32'h86); wr(6'h31, 5); wr(6'h32, 7);
        wr(6'h01, 32'h3F);                          // R9 enable set alias
        rd(6'h00, "R9");
        idle(40);
        rd(6'h23, "R4"); rd(6'h08, "R5"); rd(6'h37, "R2"); rd(6'h27, "R2"); rd(6'h33, "R2");

        // R10 open masks piecewise
        wr(6'h0E, 32'h0_2020);                      // solo line only
        idle(30);
        wr(6'h0E, 32'h0_0001);                      // ch0 full to shared line
        rd(6'h0C, "R9");
        idle(20);
        wr(6'h0A, 32'h1FFFF);                       // R8 clear all
        rd(6'h08, "R8");
        wr(6'h0D, 32'h0_0020);                      // mask set alias
        idle(20);

        // R7 gating and watchdog enable
        wr(6'h05, 32'h101);
        rd(6'h23, "R7"); idle(20); rd(6'h23, "R7"); rd(6'h04, "R9");
        wr(6'h06, 32'h100);
        idle(10);
        wr(6'h06, 32'h001);
        // R7 disable clears
        wr(6'h02, 32'h01);
        idle(5); rd(6'h23, "R7");
        wr(6'h01, 32'h01);

        // R13 count load, above full value
        wr(6'h23, 32'h1234); rd(6'h23, "R13"); idle(4); rd(6'h23, "R13");
        wr(6'h23, 32'h0001); rd(6'h23, "R13");

        // R8 event and clear collide: full 1 wraps on every core tick
        wr(6'h22, 1);
        repeat (6) begin wr(6'h0A, 32'h1); rd(6'h08, "R8"); end
        wr(6'h22, 6);

        // R11 R12 system timer
        wr(6'h10, 32'h01); wr(6'h11, 32'h40); wr(6'h12, 0);
        wr(6'h01, 32'h100);
        wr(6'h0E, 32'h10000);
        idle(80);
        rd(6'h13, "R12"); rd(6'h14, "R12"); rd(6'h08, "R11");
        wr(6'h05, 32'h200); idle(10); rd(6'h13, "R11");
        wr(6'h06, 32'h200);
        wr(6'h10, 32'h12); idle(60); rd(6'h13, "R11"); rd(6'h14, "R12");

        // R3 long divisions on ch2 and ch3
        idle(11000);
        rd(6'h2B, "R3"); rd(6'h2F, "R3"); rd(6'h08, "R3");
        wr(6'h0A, 32'h1FFFF);
        idle(5);
        rd(6'h08, "R8");

        done = 1;
        idle(2);
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule